// File: doc/BRIEF.md
# Prescaled Modulo Timer with One Capture/Compare/PWM Channel

This block is a general-purpose timer. One of four count sources feeds a power-of-two prescaler. The prescaler's output advances a counter that is bounded by a programmable modulo. The counter either climbs to the modulo and restarts at zero, or climbs and then descends for center-aligned waveforms. Each return to zero raises a sticky overflow flag.

A single channel shares the counter. It can take a time stamp of an input pin edge, drive a pin on a counter match, or produce a pulse-width-modulated signal. In PWM, a newly written duty waits until the next period boundary before it takes effect. Both flags have an enable that steers them onto one interrupt line.

The counter is a two-state machine. CNT_UP advances by one on every tick. At the top value it takes one of two transitions: UP_WRAP returns to zero, and UP_TURN moves to CNT_DOWN when center mode is on. CNT_DOWN steps down by one. At the bottom it takes DOWN_WRAP back to CNT_UP; if center mode is dropped it takes DOWN_EXIT instead.

The channel state register follows the mode inputs on every clock. It selects one of CH_CAPTURE, CH_COMPARE, CH_EPWM and CH_CPWM. The transition from any state to any other is named by its target: TO_CAPTURE, TO_COMPARE, TO_EPWM or TO_CPWM. Reset enters CH_CAPTURE.

Top module: `pmt_top`

## Requirements
- R1: `clk_sel` chooses the count source. 0 is stopped (the counter holds its value), 1 is every clock, and 2 is each clock in which `fixed_tick` is high. 3 is each rising edge of `ext_clk`, after a synchroniser of SYNC_STAGES flops.
- R2: `presc` = p divides the source by 2^p. After reset the counter advances on the 2^p-th, 2·2^p-th, … source event.
- R3: With `center_en` low the counter steps 0, 1, …, top, 0, … Top is `modulo`, or the all-ones value when `modulo` is 0.
- R4: With `center_en` high the counter steps 0, 1, …, top, top−1, …, 1, 0, giving a period of 2·top ticks.
- R5: `ovf_flag` sets on the tick that brings the counter back to 0. In center mode this is only the bottom turnaround. The flag stays set until `ovf_clr`, and a new set wins over a clear in the same cycle.
- R6: With `ch_mode`=00, `ch_edge` bit0 enables capture on rising edges and bit1 enables capture on falling edges. A capture loads `ch_value` with the count present SYNC_STAGES clocks after the pin change and sets `ch_flag`. An edge whose enable bit is clear changes nothing.
- R7: With `ch_mode`=01, a tick that makes the count equal `ch_value` sets `ch_flag` and acts on the pin. `ch_edge` 01 toggles the pin, 10 drives it low, 11 drives it high, and 00 leaves it unchanged. The pin changes on the same clock as the count.
- R8: With `ch_mode`=1x, the pin is updated on every tick. It is at the active level while the new count is below the duty, and at the other level otherwise. `ch_edge` bit0=0 makes high the active level; bit0=1 makes low the active level. `ch_flag` sets when the new count equals the duty. In center mode the active width is 2·duty−1 ticks.
- R9: In PWM, a write lands in a holding register. `ch_value` and the pin keep the old duty until the next return of the counter to 0. In the other modes a write loads `ch_value` directly.
- R10: `ch_flag` is sticky until `ch_clr`. `irq` is high exactly when a set flag has its enable (`ovf_ie`, `ch_ie`) set.
- R11: During reset the count, `ch_value`, both flags, `irq` and the pin are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Count source code |
| presc | input | PRE_W | Prescale exponent |
| center_en | input | 1 | Up/down counting |
| modulo | input | CNT_W | Counter top (0 = all ones) |
| ch_mode | input | 2 | Channel mode |
| ch_edge | input | 2 | Edge, pin action or polarity bits |
| ch_wr | input | 1 | Write strobe for the channel value |
| ch_wdata | input | CNT_W | Channel write data |
| ch_pin_in | input | 1 | Capture pin |
| fixed_tick | input | 1 | Fixed-rate source enable |
| ext_clk | input | 1 | External clock pin |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ch_ie | input | 1 | Channel interrupt enable |
| ovf_clr | input | 1 | Clear overflow flag |
| ch_clr | input | 1 | Clear channel flag |
| count | output | CNT_W | Counter value |
| ch_value | output | CNT_W | Active channel value |
| ovf_flag | output | 1 | Overflow flag |
| ch_flag | output | 1 | Channel flag |
| irq | output | 1 | Interrupt request |
| ch_pin_out | output | 1 | Channel output pin |

## Verification
The bench builds the block with CNT_W=8, PRE_W=3 and SYNC_STAGES=2. The narrow counter makes the free-running wrap at 255 reachable in a few hundred cycles. It also brings the second compare match one full counter period later within reach. PRE_W=3 gives the full range of divisors, including the largest prescale of 128. Two synchroniser stages fix the capture offset at two counts, so the bench can predict captured values exactly.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_BUS   = 2'd1,
        SRC_FIXED = 2'd2,
        SRC_EXT   = 2'd3
    } src_e;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        CH_CAPTURE = 2'd0,
        CH_COMPARE = 2'd1,
        CH_EPWM    = 2'd2,
        CH_CPWM    = 2'd3
    } ch_state_e;

endpackage

// File: rtl/pmt_tickgen.sv
module pmt_tickgen #(
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel,
    input  logic [PRE_W-1:0] presc,
    input  logic             fixed_tick,
    input  logic             ext_clk,
    output logic             tick
);
    import pmt_pkg::*;

    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [SYNC_STAGES-1:0] ext_sync;
    logic                   ext_prev;
    logic                   ext_rise;
    logic                   src_en;
    logic [DIV_W-1:0]       pre_q;
    logic [DIV_W-1:0]       mask;

    // external pin: synchroniser chain then rising-edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sync <= '0;
            ext_prev <= 1'b0;
        end else begin
            ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_clk};
            ext_prev <= ext_sync[SYNC_STAGES-1];
        end
    end

    assign ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_prev;

    always_comb begin
        unique case (clk_sel)
            SRC_OFF:   src_en = 1'b0;
            SRC_BUS:   src_en = 1'b1;
            SRC_FIXED: src_en = fixed_tick;
            SRC_EXT:   src_en = ext_rise;
            default:   src_en = 1'b0;
        endcase
    end

    // a shift past the top bit wraps to zero, so the mask becomes all ones
    assign mask = (DIV_W'(1) << presc) - DIV_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (src_en) begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end

    assign tick = src_en && ((pre_q & mask) == mask);

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center_en,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             wrap_evt
);
    import pmt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] top;

    assign top = (modulo == '0) ? '1 : modulo;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_UP;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        count_d  = count_q;
        wrap_evt = 1'b0;
        if (tick) begin
            unique case (state_q)
                CNT_UP: begin
                    if (count_q < top) begin
                        count_d = count_q + ONE;
                    end else if (!center_en || count_q <= ONE) begin
                        // UP_WRAP
                        count_d  = '0;
                        wrap_evt = 1'b1;
                    end else begin
                        // UP_TURN
                        count_d = count_q - ONE;
                        state_d = CNT_DOWN;
                    end
                end
                CNT_DOWN: begin
                    if (!center_en) begin
                        // DOWN_EXIT: resume plain up counting
                        state_d = CNT_UP;
                        if (count_q < top) begin
                            count_d = count_q + ONE;
                        end else begin
                            count_d  = '0;
                            wrap_evt = 1'b1;
                        end
                    end else if (count_q <= ONE) begin
                        // DOWN_WRAP
                        count_d  = '0;
                        wrap_evt = 1'b1;
                        state_d  = CNT_UP;
                    end else begin
                        count_d = count_q - ONE;
                    end
                end
            endcase
        end
    end

    assign count     = count_q;
    assign count_nxt = count_d;

endmodule

// File: rtl/pmt_channel.sv
module pmt_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ch_mode,
    input  logic [1:0]       ch_edge,
    input  logic             center_en,
    input  logic             ch_wr,
    input  logic [CNT_W-1:0] ch_wdata,
    input  logic             ch_pin_in,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             wrap_evt,
    output logic [CNT_W-1:0] ch_value,
    output logic             ch_pin_out,
    output logic             ch_evt
);
    import pmt_pkg::*;

    ch_state_e              state_q, state_d;
    logic [CNT_W-1:0]       val_q, val_d;
    logic [CNT_W-1:0]       buf_q, buf_d;
    logic                   pin_q, pin_d;
    logic [SYNC_STAGES-1:0] pin_sync;
    logic                   pin_prev;
    logic                   pin_rise, pin_fall;
    logic [CNT_W-1:0]       duty_eff;
    logic                   active_lvl;
    logic                   pwm_lvl;

    // capture pin synchroniser and edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_sync <= '0;
            pin_prev <= 1'b0;
        end else begin
            pin_sync <= {pin_sync[SYNC_STAGES-2:0], ch_pin_in};
            pin_prev <= pin_sync[SYNC_STAGES-1];
        end
    end

    assign pin_rise = pin_sync[SYNC_STAGES-1] & ~pin_prev;
    assign pin_fall = ~pin_sync[SYNC_STAGES-1] & pin_prev;

    // next-state: TO_CAPTURE, TO_COMPARE, TO_EPWM, TO_CPWM
    always_comb begin
        if (ch_mode[1]) begin
            state_d = center_en ? CH_CPWM : CH_EPWM;
        end else begin
            state_d = ch_mode[0] ? CH_COMPARE : CH_CAPTURE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_CAPTURE;
            val_q   <= '0;
            buf_q   <= '0;
            pin_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            val_q   <= val_d;
            buf_q   <= buf_d;
            pin_q   <= pin_d;
        end
    end

    // duty in force for the count being entered
    assign duty_eff   = wrap_evt ? buf_q : val_q;
    assign active_lvl = ~ch_edge[0];
    assign pwm_lvl    = (count_nxt < duty_eff) ? active_lvl : ~active_lvl;

    // outputs
    always_comb begin
        val_d  = val_q;
        buf_d  = buf_q;
        pin_d  = pin_q;
        ch_evt = 1'b0;
        unique case (state_q)
            CH_CAPTURE: begin
                if (ch_wr) begin
                    val_d = ch_wdata;
                    buf_d = ch_wdata;
                end
                if ((ch_edge[0] && pin_rise) || (ch_edge[1] && pin_fall)) begin
                    val_d  = count;
                    ch_evt = 1'b1;
                end
            end
            CH_COMPARE: begin
                if (ch_wr) begin
                    val_d = ch_wdata;
                    buf_d = ch_wdata;
                end
                if (tick && (count_nxt == val_q)) begin
                    ch_evt = 1'b1;
                    unique case (ch_edge)
                        2'b01:   pin_d = ~pin_q;
                        2'b10:   pin_d = 1'b0;
                        2'b11:   pin_d = 1'b1;
                        default: pin_d = pin_q;
                    endcase
                end
            end
            CH_EPWM, CH_CPWM: begin
                if (ch_wr) begin
                    buf_d = ch_wdata;
                end
                if (tick) begin
                    if (wrap_evt) begin
                        val_d = buf_q;
                    end
                    pin_d = pwm_lvl;
                    if (count_nxt == duty_eff) begin
                        ch_evt = 1'b1;
                    end
                end
            end
        endcase
    end

    assign ch_value   = val_q;
    assign ch_pin_out = pin_q;

endmodule

// File: rtl/pmt_top.sv
module pmt_top #(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel,
    input  logic [PRE_W-1:0] presc,
    input  logic             center_en,
    input  logic [CNT_W-1:0] modulo,
    input  logic [1:0]       ch_mode,
    input  logic [1:0]       ch_edge,
    input  logic             ch_wr,
    input  logic [CNT_W-1:0] ch_wdata,
    input  logic             ch_pin_in,
    input  logic             fixed_tick,
    input  logic             ext_clk,
    input  logic             ovf_ie,
    input  logic             ch_ie,
    input  logic             ovf_clr,
    input  logic             ch_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] ch_value,
    output logic             ovf_flag,
    output logic             ch_flag,
    output logic             irq,
    output logic             ch_pin_out
);

    logic             tick;
    logic [CNT_W-1:0] count_nxt;
    logic             wrap_evt;
    logic             ch_evt;
    logic             ovf_q;
    logic             chf_q;

    pmt_tickgen #(
        .PRE_W      (PRE_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .presc     (presc),
        .fixed_tick(fixed_tick),
        .ext_clk   (ext_clk),
        .tick      (tick)
    );

    pmt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .center_en(center_en),
        .modulo   (modulo),
        .count    (count),
        .count_nxt(count_nxt),
        .wrap_evt (wrap_evt)
    );

    pmt_channel #(
        .CNT_W      (CNT_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_mode   (ch_mode),
        .ch_edge   (ch_edge),
        .center_en (center_en),
        .ch_wr     (ch_wr),
        .ch_wdata  (ch_wdata),
        .ch_pin_in (ch_pin_in),
        .tick      (tick),
        .count     (count),
        .count_nxt (count_nxt),
        .wrap_evt  (wrap_evt),
        .ch_value  (ch_value),
        .ch_pin_out(ch_pin_out),
        .ch_evt    (ch_evt)
    );

    // sticky flags, a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            chf_q <= 1'b0;
        end else begin
            if (wrap_evt) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
            if (ch_evt) begin
                chf_q <= 1'b1;
            end else if (ch_clr) begin
                chf_q <= 1'b0;
            end
        end
    end

    assign ovf_flag = ovf_q;
    assign ch_flag  = chf_q;
    assign irq      = (ovf_q & ovf_ie) | (chf_q & ch_ie);

endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       clk_sel,
    input logic [PRE_W-1:0] presc,
    input logic             center_en,
    input logic [CNT_W-1:0] modulo,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic             ch_flag,
    input logic             ch_clr,
    input logic             irq
);

    a_r1_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'd0) |=> $stable(count));

    a_r2_div1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'd1 && presc == '0 && !center_en && modulo == '0)
        |=> (count == CNT_W'($past(count) + 1'b1)));

    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!center_en && $past(!center_en) && count != $past(count))
        |-> (count == CNT_W'($past(count) + 1'b1) || count == '0));

    a_r4_center_step: assert property (@(posedge clk) disable iff (!rst_n)
        (center_en && $past(center_en) && count != $past(count))
        |-> (count == CNT_W'($past(count) + 1'b1) || count == CNT_W'($past(count) - 1'b1)));

    a_r5_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    a_r10_ch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag && !ch_clr) |=> ch_flag);

    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag || ch_flag));

endmodule

bind pmt_top pmt_checker #(
    .CNT_W(CNT_W),
    .PRE_W(PRE_W)
) u_pmt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .presc    (presc),
    .center_en(center_en),
    .modulo   (modulo),
    .count    (count),
    .ovf_flag (ovf_flag),
    .ovf_clr  (ovf_clr),
    .ch_flag  (ch_flag),
    .ch_clr   (ch_clr),
    .irq      (irq)
);

// File: tb/tb_pmt_top.sv
module tb_pmt_top;

    localparam int CNT_W = 8;
    localparam int PRE_W = 3;
    localparam int SYNC  = 2;
    localparam int NVEC  = 8;

    // {presc, center, modulo, cycles, exp_count, exp_ovf}
    localparam logic [36:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 8'd10,  16'd25,  8'd3,  1'b1},
        {3'd2, 1'b0, 8'd5,   16'd30,  8'd1,  1'b1},
        {3'd7, 1'b0, 8'd0,   16'd300, 8'd2,  1'b0},
        {3'd0, 1'b0, 8'd0,   16'd300, 8'd44, 1'b1},
        {3'd0, 1'b1, 8'd4,   16'd6,   8'd2,  1'b0},
        {3'd1, 1'b1, 8'd3,   16'd21,  8'd2,  1'b1},
        {3'd0, 1'b1, 8'd4,   16'd4,   8'd4,  1'b0},
        {3'd3, 1'b0, 8'd200, 16'd100, 8'd12, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       clk_sel = 2'd1;
    logic [PRE_W-1:0] presc = '0;
    logic             center_en = 1'b0;
    logic [CNT_W-1:0] modulo = '0;
    logic [1:0]       ch_mode = 2'b00;
    logic [1:0]       ch_edge = 2'b00;
    logic             ch_wr = 1'b0;
    logic [CNT_W-1:0] ch_wdata = '0;
    logic             ch_pin_in = 1'b0;
    logic             fixed_tick = 1'b0;
    logic             ext_clk = 1'b0;
    logic             ovf_ie = 1'b0;
    logic             ch_ie = 1'b0;
    logic             ovf_clr = 1'b0;
    logic             ch_clr = 1'b0;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] ch_value;
    logic             ovf_flag;
    logic             ch_flag;
    logic             irq;
    logic             ch_pin_out;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pmt_top #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .presc(presc),
        .center_en(center_en), .modulo(modulo), .ch_mode(ch_mode),
        .ch_edge(ch_edge), .ch_wr(ch_wr), .ch_wdata(ch_wdata),
        .ch_pin_in(ch_pin_in), .fixed_tick(fixed_tick), .ext_clk(ext_clk),
        .ovf_ie(ovf_ie), .ch_ie(ch_ie), .ovf_clr(ovf_clr), .ch_clr(ch_clr),
        .count(count), .ch_value(ch_value), .ovf_flag(ovf_flag),
        .ch_flag(ch_flag), .irq(irq), .ch_pin_out(ch_pin_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ch_wr = 1'b0;
        ch_pin_in = 1'b0;
        fixed_tick = 1'b0;
        ext_clk = 1'b0;
        ovf_clr = 1'b0;
        ch_clr = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic wr_ch(input int v);
        ch_wdata = CNT_W'(v);
        ch_wr = 1'b1;
        step(1);
        ch_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11 reset values
        @(negedge clk);
        step(2);
        chk("R11 count", count, 0);
        chk("R11 ch_value", ch_value, 0);
        chk("R11 ovf_flag", ovf_flag, 0);
        chk("R11 ch_flag", ch_flag, 0);
        chk("R11 irq", irq, 0);
        chk("R11 pin", ch_pin_out, 0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            clk_sel   = 2'd1;
            presc     = VEC[i][36:34];
            center_en = VEC[i][33];
            modulo    = VEC[i][32:25];
            ch_mode   = 2'b00;
            ch_edge   = 2'b00;
            ovf_ie    = 1'b1;
            ch_ie     = 1'b0;
            do_reset();
            step(int'(VEC[i][24:9]));
            chk($sformatf("R2/R3/R4 vec%0d count", i), count, int'(VEC[i][8:1]));
            chk($sformatf("R5 vec%0d ovf", i), ovf_flag, int'(VEC[i][0]));
            chk($sformatf("R10 vec%0d irq", i), irq, int'(VEC[i][0]));
        end

        // R5 exact set point and clear
        presc = '0; center_en = 1'b0; modulo = 8'd3; ovf_ie = 1'b1;
        do_reset();
        step(3);
        chk("R5 before wrap", ovf_flag, 0);
        chk("R3 count at top", count, 3);
        step(1);
        chk("R5 set on wrap", ovf_flag, 1);
        chk("R3 wrapped to 0", count, 0);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        chk("R5 cleared", ovf_flag, 0);
        chk("R10 irq drops", irq, 0);

        // R1 stopped source
        clk_sel = 2'd0; modulo = '0;
        do_reset();
        step(50);
        chk("R1 off holds", count, 0);

        // R1 fixed source
        clk_sel = 2'd2;
        do_reset();
        step(10);
        chk("R1 fixed idle", count, 0);
        for (int k = 0; k < 5; k++) begin
            fixed_tick = 1'b1;
            step(1);
            fixed_tick = 1'b0;
            step(1);
        end
        chk("R1 fixed pulses", count, 5);

        // R1 external source
        clk_sel = 2'd3;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            ext_clk = 1'b1;
            step(3);
            ext_clk = 1'b0;
            step(3);
        end
        step(3);
        chk("R1 ext edges", count, 4);

        // R6 capture, R10 channel flag and irq
        clk_sel = 2'd1; modulo = '0; ch_mode = 2'b00; ch_edge = 2'b01;
        ovf_ie = 1'b0; ch_ie = 1'b1;
        do_reset();
        step(5);
        ch_pin_in = 1'b1;
        step(2);
        chk("R6 no flag yet", ch_flag, 0);
        chk("R10 irq low", irq, 0);
        step(1);
        chk("R6 rise value", ch_value, 5 + SYNC);
        chk("R6 rise flag", ch_flag, 1);
        chk("R10 irq high", irq, 1);
        ch_clr = 1'b1;
        step(1);
        ch_clr = 1'b0;
        chk("R10 ch cleared", ch_flag, 0);
        ch_pin_in = 1'b0;
        step(5);
        chk("R6 fall ignored flag", ch_flag, 0);
        chk("R6 fall ignored value", ch_value, 7);
        ch_edge = 2'b11;
        ch_pin_in = 1'b1;
        step(3);
        chk("R6 both rise", ch_value, 16);
        chk("R6 both rise flag", ch_flag, 1);
        ch_clr = 1'b1;
        step(1);
        ch_clr = 1'b0;
        ch_pin_in = 1'b0;
        step(3);
        chk("R6 both fall", ch_value, 20);
        chk("R6 both fall flag", ch_flag, 1);

        // R7 output compare
        ch_mode = 2'b01; ch_edge = 2'b01; ch_ie = 1'b0;
        do_reset();
        step(2);
        wr_ch(20);
        chk("R9 direct write", ch_value, 20);
        step(16);
        chk("R7 pin before match", ch_pin_out, 0);
        chk("R7 flag before match", ch_flag, 0);
        step(1);
        chk("R7 toggle on match", ch_pin_out, 1);
        chk("R7 flag on match", ch_flag, 1);
        chk("R7 count at match", count, 20);
        ch_edge = 2'b10;
        step(255);
        chk("R7 held between matches", ch_pin_out, 1);
        step(1);
        chk("R7 clear on match", ch_pin_out, 0);

        // R8 R9 edge-aligned PWM, high true
        modulo = 8'd9; ch_mode = 2'b10; ch_edge = 2'b10;
        do_reset();
        step(2);
        wr_ch(3);
        step(2);
        chk("R9 duty held before boundary", ch_value, 0);
        chk("R8 pin inactive duty0", ch_pin_out, 0);
        step(5);
        chk("R8 pin active at period start", ch_pin_out, 1);
        chk("R9 duty loaded", ch_value, 3);
        step(2);
        chk("R8 pin active below duty", ch_pin_out, 1);
        chk("R8 flag before match", ch_flag, 0);
        step(1);
        chk("R8 pin off at duty", ch_pin_out, 0);
        chk("R8 flag at match", ch_flag, 1);
        step(1);
        wr_ch(6);
        step(2);
        chk("R9 old duty mid period", ch_value, 3);
        chk("R9 pin follows old duty", ch_pin_out, 0);
        step(7);
        chk("R9 new duty in force", ch_value, 6);
        chk("R9 pin with new duty", ch_pin_out, 1);
        step(2);
        chk("R9 pin off at new duty", ch_pin_out, 0);

        // R8 low-true polarity
        ch_edge = 2'b01;
        do_reset();
        step(2);
        wr_ch(3);
        step(2);
        chk("R8 low-true idle", ch_pin_out, 1);
        step(5);
        chk("R8 low-true active", ch_pin_out, 0);
        step(3);
        chk("R8 low-true after duty", ch_pin_out, 1);

        // R4 R8 center-aligned PWM
        modulo = 8'd4; center_en = 1'b1; ch_edge = 2'b10; ovf_ie = 1'b0;
        do_reset();
        step(2);
        wr_ch(2);
        step(4);
        chk("R8 center pin before load", ch_pin_out, 0);
        chk("R5 center no ovf at top", ovf_flag, 0);
        step(1);
        chk("R5 center ovf at bottom", ovf_flag, 1);
        chk("R4 center bottom", count, 0);
        step(1);
        chk("R8 center pin active", ch_pin_out, 1);
        chk("R8 center flag before", ch_flag, 0);
        step(1);
        chk("R8 center pin off", ch_pin_out, 0);
        chk("R8 center flag", ch_flag, 1);
        step(4);
        chk("R4 center descending", count, 2);
        chk("R8 center pin still off", ch_pin_out, 0);
        step(1);
        chk("R8 center pin back on", ch_pin_out, 1);
        step(2);
        chk("R8 center pin held", ch_pin_out, 1);
        step(1);
        chk("R8 center width end", ch_pin_out, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule